// File: doc/BRIEF.md
# System Control Register Block

This block is the control and status register file of a small dual-core subsystem. It answers a 32-bit memory-mapped slave port that decodes a 4 KB window. Through that port software reads why the last reset happened and sets the mask of allowed reset sources. It also sets or clears bits of a secure-debug status word, loads the boot vector of each core and holds each core in a wait state until software lets it go. Clock-divider and clock-force settings and the boot vectors leave the block as level outputs. A core release and a software reset request leave it as one-cycle pulses. The clock dividers, power controllers and reset generator are outside the block.

An access is presented for one cycle on `req_i` with `we_i`, `addr_i`, `wdata_i` and `be_i`. Read data and the error flag appear on `rdata_o` and `err_o` in the following cycle. The extended register set is present only when bits [31:28] of the `VERSION` parameter equal 2. With any other version those offsets read as zero and writes to them are ignored without error.

Top module: `sys_ctrl_regs`

## Requirements
- R1: After reset the registers hold these values: reset cause (0x100) = 1, reset mask (0x104) = 0, power sense system (0x200) = 0x7F, power sense SRAM words = 0, debug status = 0, clock settings = 0, wait bits = `CPU_WAIT_RST`, and `vec0_o`/`vec1_o` = `VEC0_RST`/`VEC1_RST`. No pulse or error output is high.
- R2: Several registers read back exactly the last value written: reset cause 0x100, reset mask 0x104, clock divider 0x014, clock force 0x018, NMI enable 0x11C, power sense 0x200 and SRAM sense 0x20C + 4·k (k = 0..3). Read data appears on `rdata_o` one cycle after the access.
- R3: A write stores the whole 32-bit word. Byte lanes whose `be_i` bit is 0 are stored as zero. `be_i[n]` covers `wdata_i[8n+7:8n]`. Reads ignore `be_i` and return the full word.
- R4: Writing 0x004 ORs the written value into the debug status word. Writing 0x008 clears every status bit written as 1. The word reads at 0x000.
- R5: The wait register at 0x10C holds bit k for core k. A write that takes bit k from 1 to 0 gives a one-cycle `core_rel_o[k]` pulse in the cycle after the write. Writes that leave a bit at 0 or at 1 give no pulse. Both cores may be released by one write.
- R6: A write to 0x108 with bit 9 set (after lane masking) gives a one-cycle `sw_rst_req_o` pulse in the cycle after the write. All other bits of that word have no effect.
- R7: Writes to 0x110 and 0x114 set `vec0_o` and `vec1_o`. Both read back.
- R8: The twelve words from 0xFD0 to 0xFFC read, in address order, 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. A write there is ignored and sets `err_o`. A write to the status word 0x000 is also ignored and sets `err_o`.
- R9: When `VERSION[31:28]` is not 2, offsets 0x014, 0x018, 0x114, 0x11C, 0x200 and 0x20C–0x218 read 0, ignore writes and give no error.
- R10: A read of the write-only offsets 0x004, 0x008 and 0x108 returns 0 and sets `err_o`.
- R11: An access to an unmapped offset returns 0 and sets `err_o` for exactly the one cycle after the access.
- R12: `clk_div_o` and `clk_force_o` show the stored clock divider and clock force words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address in the window |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte lane enables |
| rdata_o | output | 32 | Read data, one cycle after a read |
| err_o | output | 1 | Access error, one cycle after the access |
| vec0_o | output | 32 | Boot vector, core 0 |
| vec1_o | output | 32 | Boot vector, core 1 |
| clk_div_o | output | 32 | Clock divider setting |
| clk_force_o | output | 32 | Clock force setting |
| core_wait_o | output | 2 | Per-core wait bits |
| core_rel_o | output | 2 | Per-core release pulses |
| sw_rst_req_o | output | 1 | Software reset request pulse |

## Verification
The two core releases can fall in the same cycle, because one write to the wait register can clear both bits. The bench first holds both cores waiting and releases one of them. It then sets both bits again and clears both with a single write. It expects both `core_rel_o` bits high in the cycle after that write and both low one cycle later. It also checks the mixed case, where one bit falls while the other stays set, to confirm that only the falling core gets a pulse.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int AW     = 12;
  localparam int DW     = 32;
  localparam int NCORE  = 2;
  localparam int IDXW   = 4;
  localparam int SWR_BIT = 9;

  localparam logic [AW-1:0] OFF_DBG_STAT  = 12'h000;
  localparam logic [AW-1:0] OFF_DBG_SET   = 12'h004;
  localparam logic [AW-1:0] OFF_DBG_CLR   = 12'h008;
  localparam logic [AW-1:0] OFF_CLK_DIV   = 12'h014;
  localparam logic [AW-1:0] OFF_CLK_FORCE = 12'h018;
  localparam logic [AW-1:0] OFF_RST_CAUSE = 12'h100;
  localparam logic [AW-1:0] OFF_RST_MASK  = 12'h104;
  localparam logic [AW-1:0] OFF_SW_RST    = 12'h108;
  localparam logic [AW-1:0] OFF_CPU_WAIT  = 12'h10C;
  localparam logic [AW-1:0] OFF_VEC0      = 12'h110;
  localparam logic [AW-1:0] OFF_VEC1      = 12'h114;
  localparam logic [AW-1:0] OFF_NMI_EN    = 12'h11C;
  localparam logic [AW-1:0] OFF_PD_SYS    = 12'h200;
  localparam logic [AW-1:0] OFF_PD_SRAM   = 12'h20C;
  localparam logic [AW-1:0] OFF_ID        = 12'hFD0;

  typedef enum logic [4:0] {
    S_NONE, S_HIDDEN, S_DBG_STAT, S_DBG_SET, S_DBG_CLR, S_CLK_DIV,
    S_CLK_FORCE, S_RST_CAUSE, S_RST_MASK, S_SW_RST, S_CPU_WAIT,
    S_VEC0, S_VEC1, S_NMI_EN, S_PD_SYS, S_PD_SRAM, S_ID
  } sel_e;

  function automatic logic [DW-1:0] id_word(input logic [IDXW-1:0] i);
    case (i)
      4'd0:  id_word = 32'h04;
      4'd4:  id_word = 32'h54;
      4'd5:  id_word = 32'hB8;
      4'd6:  id_word = 32'h0B;
      4'd8:  id_word = 32'h0D;
      4'd9:  id_word = 32'hF0;
      4'd10: id_word = 32'h05;
      4'd11: id_word = 32'hB1;
      default: id_word = 32'h00;
    endcase
  endfunction
endpackage

// File: rtl/scr_decode.sv
module scr_decode
  import scr_pkg::*;
#(
  parameter int N_SRAM = 4
) (
  input  logic [AW-1:0]   addr_i,
  input  logic            ext_i,
  output sel_e            sel_o,
  output logic [IDXW-1:0] idx_o
);
  logic [AW-1:0] wa;
  assign wa = addr_i & ~AW'(3);

  always_comb begin
    sel_o = S_NONE;
    idx_o = '0;
    case (wa)
      OFF_DBG_STAT:  sel_o = S_DBG_STAT;
      OFF_DBG_SET:   sel_o = S_DBG_SET;
      OFF_DBG_CLR:   sel_o = S_DBG_CLR;
      OFF_CLK_DIV:   sel_o = ext_i ? S_CLK_DIV   : S_HIDDEN;
      OFF_CLK_FORCE: sel_o = ext_i ? S_CLK_FORCE : S_HIDDEN;
      OFF_RST_CAUSE: sel_o = S_RST_CAUSE;
      OFF_RST_MASK:  sel_o = S_RST_MASK;
      OFF_SW_RST:    sel_o = S_SW_RST;
      OFF_CPU_WAIT:  sel_o = S_CPU_WAIT;
      OFF_VEC0:      sel_o = S_VEC0;
      OFF_VEC1:      sel_o = ext_i ? S_VEC1   : S_HIDDEN;
      OFF_NMI_EN:    sel_o = ext_i ? S_NMI_EN : S_HIDDEN;
      OFF_PD_SYS:    sel_o = ext_i ? S_PD_SYS : S_HIDDEN;
      default: ;
    endcase
    for (int i = 0; i < N_SRAM; i++) begin
      if (wa == OFF_PD_SRAM + AW'(4 * i)) begin
        sel_o = ext_i ? S_PD_SRAM : S_HIDDEN;
        idx_o = IDXW'(i);
      end
    end
    if (wa >= OFF_ID) begin
      sel_o = S_ID;
      idx_o = IDXW'((wa - OFF_ID) >> 2);
    end
  end
endmodule

// File: rtl/scr_wait_ctl.sv
module scr_wait_ctl #(
  parameter int           N   = 2,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] wait_o,
  output logic [N-1:0] rel_o
);
  logic [N-1:0] wait_q, rel_q;

  for (genvar g = 0; g < N; g++) begin : g_core
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wait_q[g] <= RST[g];
        rel_q[g]  <= 1'b0;
      end else begin
        rel_q[g] <= wr_i & wait_q[g] & ~wdata_i[g];
        if (wr_i) wait_q[g] <= wdata_i[g];
      end
    end

    // R5: a release follows a 1->0 fall of that core's wait bit
    a_r5_rel_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rel_q[g] |-> (!wait_q[g] && $past(wait_q[g])));
    a_r5_rel_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rel_q[g] |=> !rel_q[g]);
  end

  assign wait_o = wait_q;
  assign rel_o  = rel_q;
endmodule

// File: rtl/sys_ctrl_regs.sv
module sys_ctrl_regs
  import scr_pkg::*;
#(
  parameter logic [31:0]    VERSION      = 32'h2000_0000,
  parameter int             N_SRAM       = 4,
  parameter logic [NCORE-1:0] CPU_WAIT_RST = '0,
  parameter logic [DW-1:0]  VEC0_RST     = 32'h1000_0000,
  parameter logic [DW-1:0]  VEC1_RST     = 32'h1000_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW/8-1:0]  be_i,
  output logic [DW-1:0]    rdata_o,
  output logic             err_o,
  output logic [DW-1:0]    vec0_o,
  output logic [DW-1:0]    vec1_o,
  output logic [DW-1:0]    clk_div_o,
  output logic [DW-1:0]    clk_force_o,
  output logic [NCORE-1:0] core_wait_o,
  output logic [NCORE-1:0] core_rel_o,
  output logic             sw_rst_req_o
);
  localparam logic EXT  = (VERSION[31:28] == 4'h2);
  localparam int   SIW  = (N_SRAM > 1) ? $clog2(N_SRAM) : 1;
  localparam int   NB   = DW / 8;

  sel_e            sel;
  logic [IDXW-1:0] idx;
  logic [DW-1:0]   wval, rd_val;
  logic            wr, rd, err_d;

  logic [DW-1:0] dbg_q, clk_div_q, clk_force_q, rst_cause_q, rst_mask_q;
  logic [DW-1:0] vec0_q, vec1_q, nmi_q, pd_sys_q, rdata_q;
  logic [DW-1:0] pd_sram_q [N_SRAM];
  logic          sw_rst_q, err_q;

  scr_decode #(.N_SRAM(N_SRAM)) u_dec (
    .addr_i(addr_i), .ext_i(EXT), .sel_o(sel), .idx_o(idx)
  );

  // unselected lanes are written as zero
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign wval[8*b +: 8] = be_i[b] ? wdata_i[8*b +: 8] : 8'h00;
  end

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  scr_wait_ctl #(.N(NCORE), .RST(CPU_WAIT_RST)) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr && sel == S_CPU_WAIT), .wdata_i(wval[NCORE-1:0]),
    .wait_o(core_wait_o), .rel_o(core_rel_o)
  );

  always_comb begin
    case (sel)
      S_DBG_STAT:  rd_val = dbg_q;
      S_CLK_DIV:   rd_val = clk_div_q;
      S_CLK_FORCE: rd_val = clk_force_q;
      S_RST_CAUSE: rd_val = rst_cause_q;
      S_RST_MASK:  rd_val = rst_mask_q;
      S_CPU_WAIT:  rd_val = DW'(core_wait_o);
      S_VEC0:      rd_val = vec0_q;
      S_VEC1:      rd_val = vec1_q;
      S_NMI_EN:    rd_val = nmi_q;
      S_PD_SYS:    rd_val = pd_sys_q;
      S_PD_SRAM:   rd_val = pd_sram_q[idx[SIW-1:0]];
      S_ID:        rd_val = id_word(idx);
      default:     rd_val = '0;
    endcase
  end

  always_comb begin
    case (sel)
      S_NONE:                         err_d = req_i;
      S_DBG_SET, S_DBG_CLR, S_SW_RST: err_d = rd;
      S_DBG_STAT, S_ID:               err_d = wr;
      default:                        err_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_q       <= '0;
      clk_div_q   <= '0;
      clk_force_q <= '0;
      rst_cause_q <= DW'(1);
      rst_mask_q  <= '0;
      vec0_q      <= VEC0_RST;
      vec1_q      <= VEC1_RST;
      nmi_q       <= '0;
      pd_sys_q    <= DW'(8'h7F);
      sw_rst_q    <= 1'b0;
      err_q       <= 1'b0;
      rdata_q     <= '0;
    end else begin
      sw_rst_q <= wr && (sel == S_SW_RST) && wval[SWR_BIT];
      err_q    <= err_d;
      if (rd) rdata_q <= rd_val;
      if (wr) begin
        case (sel)
          S_DBG_SET:   dbg_q       <= dbg_q | wval;
          S_DBG_CLR:   dbg_q       <= dbg_q & ~wval;
          S_CLK_DIV:   clk_div_q   <= wval;
          S_CLK_FORCE: clk_force_q <= wval;
          S_RST_CAUSE: rst_cause_q <= wval;
          S_RST_MASK:  rst_mask_q  <= wval;
          S_VEC0:      vec0_q      <= wval;
          S_VEC1:      vec1_q      <= wval;
          S_NMI_EN:    nmi_q       <= wval;
          S_PD_SYS:    pd_sys_q    <= wval;
          default: ;
        endcase
      end
    end
  end

  for (genvar s = 0; s < N_SRAM; s++) begin : g_sram
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pd_sram_q[s] <= '0;
      else if (wr && sel == S_PD_SRAM && idx == IDXW'(s)) pd_sram_q[s] <= wval;
    end
  end

  assign rdata_o      = rdata_q;
  assign err_o        = err_q;
  assign vec0_o       = vec0_q;
  assign vec1_o       = vec1_q;
  assign clk_div_o    = clk_div_q;
  assign clk_force_o  = clk_force_q;
  assign sw_rst_req_o = sw_rst_q;

  // R6: a reset request needs a write to the reset word one cycle earlier
  a_r6_swrst_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_req_o |-> $past(wr && sel == S_SW_RST));
  // R11: error only follows an access
  a_r11_err_after_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i));
  // R4: cleared bits are gone after a clear write
  a_r4_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == S_DBG_CLR) |=> ((dbg_q & $past(wval)) == '0));
  // R8: writing the ID area raises the error flag
  a_r8_id_write_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == S_ID) |=> err_o);
endmodule

// File: tb/tb_sys_ctrl_regs.sv
module tb_sys_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [31:0] rdata, vec0, vec1, cdiv, cforce;
  logic        err, swr;
  logic [1:0]  cwait, crel;
  logic [31:0] b_rdata, b_vec0, b_vec1, b_cdiv, b_cforce;
  logic        b_err, b_swr;
  logic [1:0]  b_cwait, b_crel;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sys_ctrl_regs #(.VERSION(32'h2000_0000), .CPU_WAIT_RST(2'b11),
                  .VEC0_RST(32'h1000_0000), .VEC1_RST(32'h1000_2000)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .rdata_o(rdata), .err_o(err),
    .vec0_o(vec0), .vec1_o(vec1), .clk_div_o(cdiv), .clk_force_o(cforce),
    .core_wait_o(cwait), .core_rel_o(crel), .sw_rst_req_o(swr));

  sys_ctrl_regs #(.VERSION(32'h1000_0000), .VEC1_RST(32'h1000_2000)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .rdata_o(b_rdata), .err_o(b_err),
    .vec0_o(b_vec0), .vec1_o(b_vec1), .clk_div_o(b_cdiv), .clk_force_o(b_cforce),
    .core_wait_o(b_cwait), .core_rel_o(b_crel), .sw_rst_req_o(b_swr));

  typedef struct packed {
    logic [3:0]  rq;
    logic        we;
    logic [11:0] a;
    logic [31:0] d;
    logic [3:0]  be;
    logic [31:0] exp;
    logic        err;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{4'd1,  1'b0, 12'h100, 32'h0,         4'hF, 32'h1,         1'b0}, // R1
    '{4'd1,  1'b0, 12'h200, 32'h0,         4'hF, 32'h7F,        1'b0}, // R1
    '{4'd8,  1'b0, 12'hFD0, 32'h0,         4'hF, 32'h04,        1'b0}, // R8
    '{4'd8,  1'b0, 12'hFE0, 32'h0,         4'hF, 32'h54,        1'b0}, // R8
    '{4'd8,  1'b0, 12'hFFC, 32'h0,         4'hF, 32'hB1,        1'b0}, // R8
    '{4'd2,  1'b1, 12'h104, 32'hA5A5_1234, 4'hF, 32'h0,         1'b0}, // R2
    '{4'd2,  1'b0, 12'h104, 32'h0,         4'hF, 32'hA5A5_1234, 1'b0}, // R2
    '{4'd3,  1'b1, 12'h014, 32'h1234_5678, 4'h5, 32'h0,         1'b0}, // R3
    '{4'd3,  1'b0, 12'h014, 32'h0,         4'h1, 32'h0034_0078, 1'b0}, // R3
    '{4'd4,  1'b1, 12'h004, 32'hF0,        4'hF, 32'h0,         1'b0}, // R4
    '{4'd4,  1'b1, 12'h004, 32'h0F,        4'hF, 32'h0,         1'b0}, // R4
    '{4'd4,  1'b0, 12'h000, 32'h0,         4'hF, 32'hFF,        1'b0}, // R4
    '{4'd4,  1'b1, 12'h008, 32'h3C,        4'hF, 32'h0,         1'b0}, // R4
    '{4'd4,  1'b0, 12'h000, 32'h0,         4'hF, 32'hC3,        1'b0}, // R4
    '{4'd10, 1'b0, 12'h004, 32'h0,         4'hF, 32'h0,         1'b1}, // R10
    '{4'd10, 1'b0, 12'h108, 32'h0,         4'hF, 32'h0,         1'b1}, // R10
    '{4'd11, 1'b0, 12'h300, 32'h0,         4'hF, 32'h0,         1'b1}, // R11
    '{4'd8,  1'b1, 12'hFD4, 32'hFFFF_FFFF, 4'hF, 32'h0,         1'b1}, // R8
    '{4'd8,  1'b0, 12'hFD4, 32'h0,         4'hF, 32'h0,         1'b0}, // R8
    '{4'd2,  1'b1, 12'h218, 32'hDEAD_BEEF, 4'hF, 32'h0,         1'b0}, // R2
    '{4'd2,  1'b0, 12'h218, 32'h0,         4'hF, 32'hDEAD_BEEF, 1'b0}, // R2
    '{4'd2,  1'b0, 12'h20C, 32'h0,         4'hF, 32'h0,         1'b0}, // R2
    '{4'd2,  1'b1, 12'h11C, 32'h1,         4'hF, 32'h0,         1'b0}, // R2
    '{4'd2,  1'b0, 12'h11C, 32'h0,         4'hF, 32'h1,         1'b0}  // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one access, then sample in the cycle after it
  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d,
                     input logic [3:0] b);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    // R1 reset state
    chk("R1 wait bits", 32'(cwait), 32'h3);
    chk("R1 vec0", vec0, 32'h1000_0000);
    chk("R1 vec1", vec1, 32'h1000_2000);
    chk("R1 pulses", {29'd0, crel, swr}, 32'h0);
    chk("R1 err", 32'(err), 32'h0);
    chk("R12 clk_div reset", cdiv, 32'h0);

    for (int i = 0; i < NV; i++) begin
      acc(TBL[i].we, TBL[i].a, TBL[i].d, TBL[i].be);
      if (!TBL[i].we)
        chk($sformatf("R%0d table %0d rdata", TBL[i].rq, i), rdata, TBL[i].exp);
      chk($sformatf("R%0d table %0d err", TBL[i].rq, i), 32'(err), 32'(TBL[i].err));
    end
    idle();
    chk("R11 err one cycle", 32'(err), 32'h0);
    chk("R12 clk_div_o", cdiv, 32'h0034_0078);
    acc(1'b1, 12'h018, 32'h0000_0101, 4'hF);
    chk("R12 clk_force_o", cforce, 32'h0000_0101);

    // R5 core release
    acc(1'b1, 12'h10C, 32'h2, 4'hF);
    chk("R5 release core0", 32'(crel), 32'h1);
    chk("R5 wait after", 32'(cwait), 32'h2);
    idle();
    chk("R5 pulse ends", 32'(crel), 32'h0);
    acc(1'b1, 12'h10C, 32'h2, 4'hF);
    chk("R5 no fall no pulse", 32'(crel), 32'h0);
    acc(1'b1, 12'h10C, 32'h3, 4'hF);
    chk("R5 rise no pulse", 32'(crel), 32'h0);
    acc(1'b1, 12'h10C, 32'h0, 4'hF);
    chk("R5 both released", 32'(crel), 32'h3);
    idle();
    chk("R5 both pulses end", 32'(crel), 32'h0);
    acc(1'b0, 12'h10C, 32'h0, 4'hF);
    chk("R5 wait readback", rdata, 32'h0);

    // R6 software reset
    acc(1'b1, 12'h108, 32'h0000_0200, 4'hF);
    chk("R6 reset request", 32'(swr), 32'h1);
    idle();
    chk("R6 pulse ends", 32'(swr), 32'h0);
    acc(1'b1, 12'h108, 32'hFFFF_FDFF, 4'hF);
    chk("R6 other bits", 32'(swr), 32'h0);
    acc(1'b1, 12'h108, 32'h0000_0200, 4'h1);
    chk("R3 masked lane no request", 32'(swr), 32'h0);

    // R7 boot vectors
    acc(1'b1, 12'h110, 32'h0800_0400, 4'hF);
    chk("R7 vec0_o", vec0, 32'h0800_0400);
    acc(1'b1, 12'h114, 32'hCAFE_0000, 4'hF);
    chk("R7 vec1_o", vec1, 32'hCAFE_0000);
    acc(1'b0, 12'h114, 32'h0, 4'hF);
    chk("R7 vec1 readback", rdata, 32'hCAFE_0000);

    // R9 hidden registers on the reduced variant
    chk("R9 hidden vec1 unchanged", b_vec1, 32'h1000_2000);
    chk("R9 hidden vec1 read", b_rdata, 32'h0);
    chk("R9 hidden no err", 32'(b_err), 32'h0);
    acc(1'b0, 12'h014, 32'h0, 4'hF);
    chk("R9 hidden clk_div read", b_rdata, 32'h0);
    chk("R9 hidden clk_div_o", b_cdiv, 32'h0);
    acc(1'b0, 12'h104, 32'h0, 4'hF);
    chk("R9 base register present", b_rdata, 32'hA5A5_1234);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule